// File: doc/BRIEF.md
# Codec Register Access Port

This block lets a host read and write the 16-bit control registers of either of two audio codecs through a small window of three registers. The window has a 16-bit data register, an index byte and a status byte. In the index byte, bit 7 selects a read (1) or a write (0), and bits 6:0 give the codec register offset. In the status byte, bit 6 selects the target codec, and one valid flag per codec records a finished read. When the host writes the index byte, the port raises one request on a simple codec request interface. The request carries the codec, the direction, the offset and the write data, and it stays up until the codec acknowledges.

Each completed access, read or write, is copied into a 256-byte shadow memory. Codec *c* owns the bytes from c·128 upward, and the 16-bit value is stored little-endian at its even offset. A separate byte read port gives access to this shadow. Odd offsets are not forwarded to a codec. An access aimed at a codec that is not fitted leaves the data register and the flags unchanged.

The host writes the window as one 32-bit word with byte enables: lanes 1:0 are the data register, lane 2 is the index byte and lane 3 is the status byte. When one write carries both the status lane and the index lane, the status lane takes effect first, so the codec select written in that same word already applies to the access.

Top module: `codec_reg_port`

## Requirements
- R1: After reset the read word `host_rdata` is 0x00000000, no request is raised, and every shadow byte reads 0x00.
- R2: Writing the index byte with bit 7 = 1 and an even offset to a fitted codec raises one read request with that offset. On the acknowledge, the data register takes `cod_rdata`.
- R3: The target codec is status bit 6 (0 = codec 0, 1 = codec 1), and `cod_sel` carries it.
- R4: A completed read sets status bit 1 for codec 0 or status bit 3 for codec 1, and the flag is visible on the cycle after the acknowledge.
- R5: At an odd offset a read sets the data register to 0x0000 and sets the valid flag at once, without a request. A write at an odd offset raises no request and changes no shadow byte.
- R6: On the acknowledge of a read or a write, shadow byte (sel·128 + offset) takes the low data byte and the next byte takes the high data byte. For a read the data is the returned value; for a write it is the data sent.
- R7: A host write that enables both lane 3 and lane 2 applies the status byte first. The access goes to the codec that the new bit 6 names.
- R8: If `codec_present[sel]` is 0, an index write raises no request, leaves the data register unchanged and sets no valid flag. The index byte itself is still stored.
- R9: A status write takes bits 7:6 from the written byte. Where the written byte has a 1 in bit 1 or bit 3, that bit is cleared. The other low bits are kept.
- R10: From the index write that raises a request until the acknowledge, `cod_req` is 1. Index writes in that window are ignored: the index byte is unchanged and no further request follows.
- R11: While `cod_req` is 1 and no acknowledge arrives, `cod_sel`, `cod_rd`, `cod_idx` and `cod_wdata` hold steady. A write request carries the data register value that includes data lanes written in the same host word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe for the window word |
| host_be | input | 4 | Byte enables: 0/1 data, 2 index, 3 status |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | {status, index, data[15:0]} |
| codec_present | input | 2 | Per-codec fitted flag |
| cod_req | output | 1 | Codec request pending |
| cod_sel | output | 1 | Target codec |
| cod_rd | output | 1 | 1 = read, 0 = write |
| cod_idx | output | 7 | Codec register offset |
| cod_wdata | output | 16 | Data for a write request |
| cod_ack | input | 1 | Codec completes the pending request |
| cod_rdata | input | 16 | Read data, valid with `cod_ack` |
| shadow_addr | input | 8 | Shadow byte address |
| shadow_rdata | output | 8 | Shadow byte at `shadow_addr` |

## Verification
The port is exercised with reads to each codec, some selected by a separate status write and some by a combined status-plus-index word, so the two ways of picking a codec can be told apart. It is also given an even-offset write, odd-offset reads and writes, and an access to a missing codec; each of these shows whether a request is issued at all, and the bench compares the codec model's request count and last write. Status writes with different patterns in bits 7:6, 3 and 1 separate write-one-to-clear from plain overwrite. A second index write during a pending read shows whether busy protection holds.

// File: rtl/cra_pkg.sv
package cra_pkg;
    localparam int DATA_W   = 16;
    localparam int IDX_W    = 7;
    localparam int N_CODEC  = 2;
    localparam int SEL_BIT  = 6;
    localparam int SH_AW    = IDX_W + 1;
    localparam int SH_DEPTH = N_CODEC << IDX_W;
    localparam logic [7:0] W1C_MASK = 8'h0A;

    function automatic int valid_pos(input logic sel);
        return sel ? 3 : 1;
    endfunction

    typedef struct packed {
        logic              busy;
        logic              rd;
        logic              sel;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] data;
        logic [7:0]        index;
    } seq_t;

    typedef struct packed {
        logic [7:0] bits;
    } stat_t;
endpackage

// File: rtl/cra_status.sv
module cra_status
    import cra_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    input  logic       set_en,
    input  logic       set_sel,
    output logic [7:0] status
);
    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en)
            st_d.bits = {wr_byte[7:6], st_q.bits[5:0] & ~(wr_byte[5:0] & W1C_MASK[5:0])};
        if (set_en)
            st_d.bits[valid_pos(set_sel)] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.bits;

    a_r4_valid_c0: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !set_sel) |=> status[1]);
    a_r4_valid_c1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && set_sel) |=> status[3]);
    a_r9_top_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (status[7:6] == $past(wr_byte[7:6])));
endmodule

// File: rtl/cra_seq.sv
module cra_seq
    import cra_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int IW  = IDX_W,
    parameter int AW  = SH_AW
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lo_we,
    input  logic          hi_we,
    input  logic [DW-1:0] data_in,
    input  logic          idx_we,
    input  logic [7:0]    idx_in,
    input  logic          sel_eff,
    input  logic [N_CODEC-1:0] present,
    input  logic          ack,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] data_q,
    output logic [7:0]    index_q,
    output logic          req,
    output logic          req_sel,
    output logic          req_rd,
    output logic [IW-1:0] req_idx,
    output logic [DW-1:0] req_wdata,
    output logic          done_valid,
    output logic          done_sel,
    output logic          shw_en,
    output logic [AW-1:0] shw_addr,
    output logic [DW-1:0] shw_data
);
    localparam int HALF = DW / 2;

    seq_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        done_valid = 1'b0;
        done_sel   = sel_eff;
        shw_en     = 1'b0;
        shw_addr   = {s_q.sel, s_q.idx};
        shw_data   = s_q.wdata;

        if (lo_we) s_d.data[HALF-1:0]  = data_in[HALF-1:0];
        if (hi_we) s_d.data[DW-1:HALF] = data_in[DW-1:HALF];

        if (s_q.busy) begin
            if (ack) begin
                s_d.busy = 1'b0;
                shw_en   = 1'b1;
                if (s_q.rd) begin
                    s_d.data   = rdata;
                    shw_data   = rdata;
                    done_valid = 1'b1;
                    done_sel   = s_q.sel;
                end
            end
        end else if (idx_we) begin
            s_d.index = idx_in;
            if (present[sel_eff]) begin
                if (idx_in[7]) begin
                    if (idx_in[0]) begin
                        s_d.data   = '0;
                        done_valid = 1'b1;
                    end else begin
                        s_d.busy = 1'b1;
                        s_d.rd   = 1'b1;
                        s_d.sel  = sel_eff;
                        s_d.idx  = idx_in[IW-1:0];
                    end
                end else if (!idx_in[0]) begin
                    s_d.busy  = 1'b1;
                    s_d.rd    = 1'b0;
                    s_d.sel   = sel_eff;
                    s_d.idx   = idx_in[IW-1:0];
                    s_d.wdata = s_d.data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign data_q    = s_q.data;
    assign index_q   = s_q.index;
    assign req       = s_q.busy;
    assign req_sel   = s_q.sel;
    assign req_rd    = s_q.rd;
    assign req_idx   = s_q.idx;
    assign req_wdata = s_q.wdata;

    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> (req && $stable(req_sel) && $stable(req_rd)
                           && $stable(req_idx) && $stable(req_wdata)));
    a_r10_index_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> $stable(index_q));
    a_r5_even_only: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !req_idx[0]);
    a_r2_read_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack && req_rd) |=> (data_q == $past(rdata)));
endmodule

// File: rtl/cra_shadow.sv
module cra_shadow #(
    parameter int AW    = cra_pkg::SH_AW,
    parameter int DW    = cra_pkg::DATA_W,
    parameter int DEPTH = cra_pkg::SH_DEPTH
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [DW-1:0]   wdata,
    input  logic [AW-1:0]   raddr,
    output logic [DW/2-1:0] rdata
);
    localparam int BW = DW / 2;

    logic [BW-1:0] mem_d [DEPTH];
    logic [BW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[{waddr[AW-1:1], 1'b0}] = wdata[BW-1:0];
            mem_d[{waddr[AW-1:1], 1'b1}] = wdata[DW-1:BW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/codec_reg_port.sv
module codec_reg_port
    import cra_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic [3:0]          host_be,
    input  logic [31:0]         host_wdata,
    output logic [31:0]         host_rdata,
    input  logic [N_CODEC-1:0]  codec_present,
    output logic                cod_req,
    output logic                cod_sel,
    output logic                cod_rd,
    output logic [IDX_W-1:0]    cod_idx,
    output logic [DATA_W-1:0]   cod_wdata,
    input  logic                cod_ack,
    input  logic [DATA_W-1:0]   cod_rdata,
    input  logic [SH_AW-1:0]    shadow_addr,
    output logic [7:0]          shadow_rdata
);
    logic [7:0]        status;
    logic [7:0]        index_q;
    logic [DATA_W-1:0] data_q;
    logic              stat_we;
    logic              sel_eff;
    logic              done_valid, done_sel;
    logic              shw_en;
    logic [SH_AW-1:0]  shw_addr;
    logic [DATA_W-1:0] shw_data;

    assign stat_we = host_we && host_be[3];
    // status lane is applied before the index lane of the same word
    assign sel_eff = stat_we ? host_wdata[24 + SEL_BIT] : status[SEL_BIT];

    cra_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (stat_we),
        .wr_byte (host_wdata[31:24]),
        .set_en  (done_valid),
        .set_sel (done_sel),
        .status  (status)
    );

    cra_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo_we      (host_we && host_be[0]),
        .hi_we      (host_we && host_be[1]),
        .data_in    (host_wdata[15:0]),
        .idx_we     (host_we && host_be[2]),
        .idx_in     (host_wdata[23:16]),
        .sel_eff    (sel_eff),
        .present    (codec_present),
        .ack        (cod_ack),
        .rdata      (cod_rdata),
        .data_q     (data_q),
        .index_q    (index_q),
        .req        (cod_req),
        .req_sel    (cod_sel),
        .req_rd     (cod_rd),
        .req_idx    (cod_idx),
        .req_wdata  (cod_wdata),
        .done_valid (done_valid),
        .done_sel   (done_sel),
        .shw_en     (shw_en),
        .shw_addr   (shw_addr),
        .shw_data   (shw_data)
    );

    cra_shadow u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (shw_en),
        .waddr (shw_addr),
        .wdata (shw_data),
        .raddr (shadow_addr),
        .rdata (shadow_rdata)
    );

    assign host_rdata = {status, index_q, data_q};

    a_r8_fitted_only: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_be[2] && !cod_req && !codec_present[sel_eff]) |=> !cod_req);
    a_r3_sel_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_be[2] && !cod_req && codec_present[sel_eff]
         && !host_wdata[16]) |=> (cod_req && cod_sel == $past(sel_eff)));
endmodule

// File: tb/codec_reg_port_tb_top.sv
module codec_reg_port_tb_top;
    localparam int LAT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [3:0]  host_be = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [1:0]  codec_present = 2'b11;
    logic        cod_req, cod_sel, cod_rd;
    logic [6:0]  cod_idx;
    logic [15:0] cod_wdata;
    logic        cod_ack = 1'b0;
    logic [15:0] cod_rdata = '0;
    logic [7:0]  shadow_addr = '0;
    logic [7:0]  shadow_rdata;

    always #10 clk = ~clk;

    codec_reg_port dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_be(host_be),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .codec_present(codec_present), .cod_req(cod_req), .cod_sel(cod_sel),
        .cod_rd(cod_rd), .cod_idx(cod_idx), .cod_wdata(cod_wdata),
        .cod_ack(cod_ack), .cod_rdata(cod_rdata),
        .shadow_addr(shadow_addr), .shadow_rdata(shadow_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int req_count = 0;
    logic [23:0] last_wr = '0;
    bit done = 0;

    function automatic logic [15:0] model_val(input logic s, input logic [6:0] i);
        return 16'h4000 + (s ? 16'h1000 : 16'h0000) + {9'd0, i};
    endfunction

    // codec model: acknowledges LAT cycles after a request appears
    initial begin
        int wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (cod_ack) begin
                cod_ack = 1'b0;
            end else if (cod_req) begin
                if (wait_cnt == LAT) begin
                    cod_ack   = 1'b1;
                    cod_rdata = model_val(cod_sel, cod_idx);
                    if (!cod_rd) last_wr = {cod_sel, cod_idx, cod_wdata};
                    req_count++;
                    wait_cnt  = 0;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    // scoreboard: kind 0 host word, 1 shadow byte, 2 request count, 3 last write, 4 cod_req
    typedef struct {
        int          kind;
        string       tag;
        logic [7:0]  addr;
        logic [31:0] exp;
    } item_t;
    item_t sb[$];

    task automatic push(input int kind, input string tag, input logic [7:0] addr,
                        input logic [31:0] exp);
        item_t it;
        it.kind = kind; it.tag = tag; it.addr = addr; it.exp = exp;
        sb.push_back(it);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() != 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                if (it.kind == 1) begin
                    shadow_addr = it.addr;
                    #1;
                end
                case (it.kind)
                    0: act = host_rdata;
                    1: act = {24'd0, shadow_rdata};
                    2: act = req_count;
                    3: act = {8'd0, last_wr};
                    default: act = {31'd0, cod_req};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d addr=%02h actual=%08h expected=%08h",
                             it.tag, it.kind, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic hw(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_be = be; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0; host_be = '0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (cod_req) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        push(0, "R1 word", 8'h00, 32'h0);
        push(4, "R1 req", 8'h00, 32'h0);
        push(1, "R1 shadow", 8'hA6, 32'h0);
        drain();

        // R2 R4 R6 read codec 0 offset 0x10
        hw(4'b0100, 32'h0090_0000);
        wait_idle();
        push(0, "R2 R4 read c0", 8'h00, 32'h0290_4010);
        push(1, "R6 shadow lo", 8'h10, 32'h10);
        push(1, "R6 shadow hi", 8'h11, 32'h40);
        push(2, "R2 one request", 8'h00, 32'd1);
        drain();

        // R3 R7 combined status+index word selects codec 1
        hw(4'b1100, 32'h40A6_0000);
        wait_idle();
        push(0, "R3 R7 read c1", 8'h00, 32'h4AA6_5026);
        push(1, "R6 shadow c1 lo", 8'hA6, 32'h26);
        push(1, "R6 shadow c1 hi", 8'hA7, 32'h50);
        drain();

        // R9 write-one-to-clear
        hw(4'b1000, 32'h4200_0000);
        push(0, "R9 clear bit1", 8'h00, 32'h48A6_5026);
        drain();
        hw(4'b1000, 32'h8800_0000);
        push(0, "R9 clear bit3", 8'h00, 32'h80A6_5026);
        drain();
        hw(4'b1000, 32'h0000_0000);

        // R6 R11 write codec 0 offset 0x1C with data lanes in same word
        hw(4'b0111, 32'h001C_BEEF);
        push(4, "R10 busy after write issue", 8'h00, 32'd1);
        drain();
        wait_idle();
        push(3, "R11 write carries data", 8'h00, {8'd0, 1'b0, 7'h1C, 16'hBEEF});
        push(1, "R6 write shadow lo", 8'h1C, 32'hEF);
        push(1, "R6 write shadow hi", 8'h1D, 32'hBE);
        push(0, "R4 write sets no flag", 8'h00, 32'h001C_BEEF);
        push(2, "R2 count after write", 8'h00, 32'd3);
        drain();

        // R5 odd read and odd write
        hw(4'b0100, 32'h0083_0000);
        push(0, "R5 odd read", 8'h00, 32'h0283_0000);
        push(4, "R5 odd read no req", 8'h00, 32'd0);
        drain();
        hw(4'b0111, 32'h0005_1234);
        push(4, "R5 odd write no req", 8'h00, 32'd0);
        drain();
        wait_idle();
        push(0, "R5 odd write word", 8'h00, 32'h0205_1234);
        push(2, "R5 count unchanged", 8'h00, 32'd3);
        push(1, "R5 shadow untouched", 8'h05, 32'h0);
        drain();

        // R8 absent codec 1
        codec_present = 2'b01;
        hw(4'b1100, 32'h4088_0000);
        wait_idle();
        push(0, "R8 absent codec", 8'h00, 32'h4288_1234);
        push(2, "R8 no request", 8'h00, 32'd3);
        drain();
        codec_present = 2'b11;
        hw(4'b1000, 32'h0000_0000);

        // R10 index write ignored while busy
        hw(4'b0100, 32'h008E_0000);
        hw(4'b0100, 32'h0092_0000);
        push(0, "R10 index frozen", 8'h00, 32'h028E_1234);
        drain();
        wait_idle();
        push(0, "R10 first read wins", 8'h00, 32'h028E_400E);
        push(2, "R10 single request", 8'h00, 32'd4);
        drain();

        done = 1;
        summary();
        $finish;
    end
endmodule